// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Error Flags

The block takes an asynchronous serial line, finds each character by its falling start edge and recovers the bits on a 16x oversampling enable. A frame has one start bit, eight data bits sent least significant bit first, an optional parity bit and one or two stop bits. Recovered bytes go into a two-entry receive queue. When the queue is full, one more completed byte waits in a holding stage. It moves into the queue as soon as a read frees a slot.

Software reads bytes oldest first through a read strobe. Two status bits report one or more bytes queued and two bytes queued. Three sticky error flags record parity mismatch, a low first stop bit and overrun, and each flag is cleared by writing 1 to it. None of the errors stops reception. A receive interrupt fires at a level chosen by a select bit. An error interrupt stays high while any flag is set. Dropping the enable empties the queue and the holding stage, and parks the receiver.

Top module: `serial_rx_unit`

## Requirements
- R1: Each bit is sampled once per bit period, 16 ticks after the previous sample. The first data sample falls 16 ticks after the start-bit check. The eight data bits assemble least significant bit first into the byte.
- R2: A frame begins only on a high-to-low transition of the line seen on a tick. If the line is high again at the start-bit check 8 ticks later, the frame is abandoned and nothing is queued.
- R3: With par_en=1, the received parity bit is checked against par_odd (1 = odd, 0 = even total of ones over data and parity). A mismatch sets err_flags[0] when that byte enters the queue, which for a held byte is the read that frees a slot. The byte is stored all the same.
- R4: A first stop bit sampled low sets err_flags[1], and the byte is still stored. With stop2=1 the second stop bit is not checked.
- R5: The queue holds two bytes and returns them oldest first on rd_data, which shows the oldest byte while rdy=1. rd_en pops it. rdy=1 when at least one byte is queued, and two_valid=1 when two are queued.
- R6: A byte that completes while the queue is full waits in the holding stage. The read that pops a byte moves it in, so two_valid stays 1.
- R7: A byte that completes while the queue is full and the holding stage is occupied replaces the held byte and sets err_flags[2]. Reception continues.
- R8: err_flags bits stay set until a 1 is written to the same bit position of err_clr, and a write of 0 leaves them unchanged.
- R9: While rx_en=0 the queue and the holding stage are emptied (rdy=0, two_valid=0) and no frame is received. The error flags are kept.
- R10: irq_rx equals rdy when irq_two=0 and two_valid when irq_two=1. irq_err is 1 exactly while any err_flags bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable; 0 flushes and parks |
| par_en | input | 1 | 1 = frame carries a parity bit |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| stop2 | input | 1 | 1 = two stop bits |
| irq_two | input | 1 | Receive interrupt on two bytes instead of one |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest queued byte |
| rdy | output | 1 | At least one byte queued |
| two_valid | output | 1 | Two bytes queued |
| err_clr | input | 3 | Write-1-to-clear strobes for err_flags |
| err_flags | output | 3 | [0] parity, [1] framing, [2] overrun |
| irq_rx | output | 1 | Receive interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The assertions assume three things about the inputs: tick16 is a single-cycle pulse, configuration inputs change only while the line is idle, and rd_en is raised only when rdy is 1. The bench drives ticks on every second clock and changes parity and stop settings only between frames, after two idle bit periods. It strobes a read only when its model of the queue holds a byte. Random bytes, parity modes and injected parity or stop faults are mixed with directed runs for the holding stage, overrun, glitch, flush and interrupt-select cases.

// File: rtl/rxu_pkg.sv
package rxu_pkg;
    // Deframer sequence states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP1 = 3'd4,
        ST_STOP2 = 3'd5
    } rx_state_e;

    // Positions in the error flag vector
    localparam int ERR_PAR = 0;
    localparam int ERR_FRM = 1;
    localparam int ERR_OVR = 2;
    localparam int ERR_W   = 3;
endpackage

// File: rtl/rxu_deframer.sv
// Serial deframer: synchronises the line and detects a falling start edge
// on a tick. It confirms the start at mid-bit, then samples data, optional
// parity and the first stop bit once per bit period.
// Assumes: tick is a one-cycle enable at OVS times the bit rate, and the
// configuration stays constant while a frame is in progress.
module rxu_deframer
    import rxu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o,
    output logic              ferr_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOPB = IDX_W'(DATA_W - 1);

    rx_state_e         state_q;
    logic [1:0]        sync_q;
    logic              prev_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  bidx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              pbit_q;
    logic              line;

    assign line = sync_q[1];

    // Two-flop synchroniser and the frame sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sync_q  <= 2'b11;
            prev_q  <= 1'b1;
            cnt_q   <= '0;
            bidx_q  <= '0;
            shreg_q <= '0;
            pbit_q  <= 1'b0;
            done_o  <= 1'b0;
            data_o  <= '0;
            perr_o  <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], rxd};
            done_o <= 1'b0;
            if (!en) begin
                state_q <= ST_IDLE;
                prev_q  <= 1'b1;
            end else if (tick) begin
                prev_q <= line;
                case (state_q)
                    ST_IDLE: begin
                        if (prev_q && !line) begin
                            state_q <= ST_START;
                            cnt_q   <= '0;
                        end
                    end
                    ST_START: begin
                        if (cnt_q == MID) begin
                            cnt_q   <= '0;
                            bidx_q  <= '0;
                            state_q <= line ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            shreg_q <= {line, shreg_q[DATA_W-1:1]};
                            if (bidx_q == TOPB) begin
                                state_q <= par_en ? ST_PAR : ST_STOP1;
                            end else begin
                                bidx_q <= bidx_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            pbit_q  <= line;
                            state_q <= ST_STOP1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP1: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            done_o  <= 1'b1;
                            data_o  <= shreg_q;
                            perr_o  <= par_en & (^shreg_q ^ pbit_q ^ par_odd);
                            ferr_o  <= ~line;
                            state_q <= stop2 ? ST_STOP2 : ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_STOP2: begin
                        if (cnt_q == LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    // data phase is entered only after the line was low at the start check
    start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA && $past(state_q) == ST_START) |-> !$past(line));

    // R1
    // a completed byte is reported only out of the first stop bit
    done_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q) == ST_STOP1);

    // R9
    // disabled receiver never reports a byte
    parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !done_o);
endmodule

// File: rtl/rxu_rxbuf.sv
// Receive queue of DEPTH entries plus one holding stage. A byte that
// arrives while the queue is full waits in the holding stage. A later
// arrival replaces it and reports overrun. Entry 0 is the oldest byte.
// Assumes: pop is raised only when the queue is not empty.
module rxu_rxbuf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [DATA_W-1:0]          din,
    input  logic                       pin,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       par_evt_o,
    output logic                       ovr_evt_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [CW-1:0]     cnt_q, n0, n1;
    logic              hold_v_q, hold_p_q;
    logic [DATA_W-1:0] hold_d_q;
    logic              pop_eff, mv_hold, in_fifo;

    // Slot arithmetic: pop first, then the held byte, then the new byte
    always_comb begin
        pop_eff   = pop && (cnt_q != '0);
        n0        = cnt_q - CW'(pop_eff);
        mv_hold   = hold_v_q && (n0 < FULL);
        n1        = n0 + CW'(mv_hold);
        in_fifo   = push && (n1 < FULL);
        par_evt_o = (mv_hold && hold_p_q) || (in_fifo && pin);
        ovr_evt_o = push && hold_v_q && !mv_hold;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [DATA_W-1:0] nxt;
        if (i < DEPTH - 1) begin : g_shift
            assign nxt = pop_eff ? mem_q[i+1] : mem_q[i];
        end else begin : g_tail
            assign nxt = mem_q[i];
        end
        // Entry update: new byte, held byte, or shift toward the head
        always_ff @(posedge clk) begin
            if (!rst_n)                          mem_q[i] <= '0;
            else if (in_fifo && n1 == CW'(i))    mem_q[i] <= din;
            else if (mv_hold && n0 == CW'(i))    mem_q[i] <= hold_d_q;
            else                                 mem_q[i] <= nxt;
        end
    end

    // Occupancy and holding-stage control
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt_q    <= '0;
            hold_v_q <= 1'b0;
            hold_p_q <= 1'b0;
            hold_d_q <= '0;
        end else begin
            cnt_q <= n1 + CW'(in_fifo);
            if (push && !in_fifo) begin
                hold_v_q <= 1'b1;
                hold_d_q <= din;
                hold_p_q <= pin;
            end else if (mv_hold) begin
                hold_v_q <= 1'b0;
            end
        end
    end

    assign head_o  = mem_q[0];
    assign count_o = cnt_q;

    // R5
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R6
    // a read from a full queue with a held byte leaves it full
    hold_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_v_q && pop && cnt_q == FULL && !flush) |=> cnt_q == FULL);

    // R7
    // overrun leaves the queue full and the holding stage occupied
    overrun_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt_o && !flush) |=> (hold_v_q && cnt_q == FULL));
endmodule

// File: rtl/serial_rx_unit.sv
// Serial receiver top: deframer feeding the two-entry queue, sticky error
// flags with write-1-to-clear, status bits and the two interrupt outputs.
// Assumes: rd_en only while rdy is 1; err_clr is a one-cycle strobe.
module serial_rx_unit
    import rxu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop2,
    input  logic              irq_two,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy,
    output logic              two_valid,
    input  logic [ERR_W-1:0]  err_clr,
    output logic [ERR_W-1:0]  err_flags,
    output logic              irq_rx,
    output logic              irq_err
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              done, perr, ferr, par_evt, ovr_evt;
    logic [DATA_W-1:0] rx_byte;
    logic [CW-1:0]     count;
    logic [ERR_W-1:0]  err_q, err_set;

    rxu_deframer #(.DATA_W(DATA_W), .OVS(OVS)) u_deframer (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .tick(tick16), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .stop2(stop2),
        .done_o(done), .data_o(rx_byte), .perr_o(perr), .ferr_o(ferr)
    );

    rxu_rxbuf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en), .push(done),
        .din(rx_byte), .pin(perr), .pop(rd_en), .head_o(rd_data),
        .count_o(count), .par_evt_o(par_evt), .ovr_evt_o(ovr_evt)
    );

    // Collect the error events into flag positions
    always_comb begin
        err_set          = '0;
        err_set[ERR_PAR] = par_evt;
        err_set[ERR_FRM] = done && ferr;
        err_set[ERR_OVR] = ovr_evt;
    end

    // Sticky flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_set;
    end

    assign err_flags = err_q;
    assign rdy       = (count != '0);
    assign two_valid = (count == CW'(DEPTH));
    assign irq_rx    = irq_two ? two_valid : rdy;
    assign irq_err   = |err_q;

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[ERR_PAR] && !err_clr[ERR_PAR]) |=> err_q[ERR_PAR]);

    // R8
    sticky_frm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q[ERR_FRM] && !err_clr[ERR_FRM]) |=> err_q[ERR_FRM]);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rdy && !two_valid);

    // R10
    err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_err) |-> $past(|err_set));
endmodule

// File: tb/test_serial_rx_unit.sv
`timescale 1ns/1ps
module test_serial_rx_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       stop2 = 1'b0;
    logic       irq_two = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rdy, two_valid, irq_rx, irq_err;
    logic [2:0] err_clr = 3'b000;
    logic [2:0] err_flags;

    int n_chk = 0;
    int n_bad = 0;

    // reference model of queue, holding stage and flags
    logic [7:0] mq [2];
    int         mcnt = 0;
    bit         mh_v = 0;
    logic [7:0] mh_d = 8'h00;
    bit         mh_p = 0;
    bit         mper = 0, mfer = 0, movr = 0;

    serial_rx_unit i_serial_rx_unit (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd), .rx_en(rx_en),
        .par_en(par_en), .par_odd(par_odd), .stop2(stop2), .irq_two(irq_two),
        .rd_en(rd_en), .rd_data(rd_data), .rdy(rdy), .two_valid(two_valid),
        .err_clr(err_clr), .err_flags(err_flags), .irq_rx(irq_rx),
        .irq_err(irq_err)
    );

    always #2 clk = ~clk;

    // tick on every second clock, changed at the falling edge
    initial forever begin
        @(negedge clk); tick16 = 1'b1;
        @(negedge clk); tick16 = 1'b0;
    end

    function automatic logic par_bit(input logic [7:0] b, input logic odd);
        return (^b) ^ odd;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_push(input logic [7:0] b, input bit p);
        if (mcnt < 2) begin
            mq[mcnt] = b; mcnt++;
            if (p) mper = 1;
        end else begin
            if (mh_v) movr = 1;
            mh_v = 1; mh_d = b; mh_p = p;
        end
    endtask

    task automatic check_state();
        @(negedge clk);
        check("R5 rdy", {31'd0, rdy}, {31'd0, mcnt > 0});
        check("R5 two_valid", {31'd0, two_valid}, {31'd0, mcnt == 2});
        check("R8 err_flags", {29'd0, err_flags}, {29'd0, movr, mfer, mper});
        check("R10 irq_rx", {31'd0, irq_rx}, {31'd0, irq_two ? (mcnt == 2) : (mcnt > 0)});
        check("R10 irq_err", {31'd0, irq_err}, {31'd0, movr | mfer | mper});
        if (mcnt > 0) check("R1 rd_data head", {24'd0, rd_data}, {24'd0, mq[0]});
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (32) @(negedge clk);
    endtask

    // send one frame with the current configuration, optional faults
    task automatic send(input logic [7:0] b, input bit bad_par, input bit bad_stop, input bit bad_stop2);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (par_en) hold_bit(par_bit(b, par_odd) ^ bad_par);
        hold_bit(!bad_stop);
        if (stop2) hold_bit(!bad_stop2);
        hold_bit(1'b1);
        hold_bit(1'b1);
        if (bad_stop) mfer = 1;
        model_push(b, par_en && bad_par);
    endtask

    task automatic read_one(input string req);
        @(negedge clk);
        check(req, {24'd0, rd_data}, {24'd0, mq[0]});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        mq[0] = mq[1];
        mcnt--;
        if (mh_v) begin
            mq[mcnt] = mh_d; mcnt++;
            if (mh_p) mper = 1;
            mh_v = 0;
        end
    endtask

    task automatic clear_flags(input logic [2:0] m);
        @(negedge clk);
        err_clr = m;
        @(negedge clk);
        err_clr = 3'b000;
        if (m[0]) mper = 0;
        if (m[1]) mfer = 0;
        if (m[2]) movr = 0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rx_en = 1'b1;
        // reset state
        check_state();

        // R1: single byte, no parity
        send(8'hA5, 0, 0, 0);
        check_state();
        read_one("R1 byte A5");
        check_state();

        // R5 R10: two bytes, interrupt on two
        irq_two = 1'b1;
        send(8'h3C, 0, 0, 0);
        check_state();
        send(8'hC3, 0, 0, 0);
        check_state();
        read_one("R5 oldest first");
        check_state();
        read_one("R5 second byte");
        irq_two = 1'b0;

        // R6: third byte held, moves in on read
        send(8'h11, 0, 0, 0);
        send(8'h22, 0, 0, 0);
        send(8'h33, 0, 0, 0);
        check_state();
        read_one("R6 first of three");
        check_state();
        read_one("R6 second of three");
        read_one("R6 held byte");
        check_state();

        // R7: fourth byte replaces the held one
        send(8'h41, 0, 0, 0);
        send(8'h42, 0, 0, 0);
        send(8'h43, 0, 0, 0);
        send(8'h44, 0, 0, 0);
        check_state();
        read_one("R7 first");
        read_one("R7 second");
        read_one("R7 replacing byte");
        check_state();
        clear_flags(3'b100);
        check_state();

        // R3: even parity fault, odd parity good
        par_en = 1'b1; par_odd = 1'b0;
        send(8'h5A, 1, 0, 0);
        check_state();
        read_one("R3 byte kept after parity fault");
        clear_flags(3'b001);
        par_odd = 1'b1;
        send(8'h07, 0, 0, 0);
        check_state();
        read_one("R3 odd parity good");

        // R3: held byte flags parity only when it enters the queue
        send(8'h01, 0, 0, 0);
        send(8'h02, 0, 0, 0);
        send(8'h03, 1, 0, 0);
        check_state();
        read_one("R3 held parity byte move");
        check_state();
        read_one("R3 q1");
        read_one("R3 q2");
        clear_flags(3'b001);
        par_en = 1'b0;

        // R4: framing fault on first stop; second stop unchecked
        send(8'h99, 0, 1, 0);
        check_state();
        read_one("R4 byte kept after framing fault");
        clear_flags(3'b010);
        stop2 = 1'b1;
        send(8'h66, 0, 0, 1);
        check_state();
        read_one("R4 second stop ignored");
        stop2 = 1'b0;

        // R8: clear with a zero mask leaves flags
        send(8'hF0, 0, 1, 0);
        clear_flags(3'b000);
        check_state();
        read_one("R8 byte");
        clear_flags(3'b111);

        // R2: short low glitch is ignored
        @(negedge clk);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (96) @(negedge clk);
        check_state();
        send(8'h5B, 0, 0, 0);
        check_state();
        read_one("R2 frame after glitch");

        // R9: disable flushes queue and holding stage
        send(8'hAA, 0, 0, 0);
        send(8'hBB, 0, 0, 0);
        send(8'hCC, 0, 0, 0);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        mcnt = 0; mh_v = 0;
        check_state();
        send(8'hDD, 0, 0, 0);
        check_state();
        read_one("R9 fresh byte after flush");

        // random phase
        for (int it = 0; it < 24; it++) begin
            if (it % 6 == 0) begin
                par_en  = 1'($urandom % 2);
                par_odd = 1'($urandom % 2);
                stop2   = 1'($urandom % 2);
                irq_two = 1'($urandom % 2);
            end
            begin
                logic [7:0] b;
                bit bp, bs;
                int nr;
                b  = 8'($urandom);
                bp = par_en && ($urandom % 4 == 0);
                bs = ($urandom % 6 == 0);
                send(b, bp, bs, 0);
                check_state();
                nr = $urandom % 3;
                for (int k = 0; k < nr; k++) begin
                    if (mcnt > 0) read_one("R1 random byte");
                end
                if ($urandom % 3 == 0) clear_flags(3'($urandom));
                check_state();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule